// File: doc/BRIEF.md
# Speculative Miss Mode Controller

This block decides when a load/store unit should stop speculating and fall back to a conservative policy. Software picks one of four modes through a 2-bit field. The register decode extracts that field from the control word and presents it on `cfg_mode_i`, qualified by `cfg_we_i`. Two of the modes are fixed: one always speculates and one never does. The other two are adaptive and rely on an 8-bit confidence counter.

In the adaptive modes, every branch mispredict pulse raises the counter by a step. The step is 4 in one adaptive mode and 8 in the other. Every retired conditional branch lowers the counter by one. The counter saturates at both ends instead of wrapping. While an adaptive mode is selected, conservative operation is requested whenever bit 7 of the counter is set.

The output `conservative_o` is registered. It reflects the mode and the counter value after the update made at the same clock edge.

Top module: `spec_throttle_ctrl`

## Requirements
- R1: Reset sets the mode to 00 and the counter to 0, so `conservative_o` is low. A mode value on `cfg_mode_i` takes effect only in a cycle where `cfg_we_i` is high.
- R2: In mode 00 (full speculation), `conservative_o` is 0.
- R3: In mode 01 (forced conservative), `conservative_o` is 1.
- R4: In mode 10, each cycle with `mispredict_i` high and `retire_i` low adds 4 to the counter.
- R5: In mode 11, each cycle with `mispredict_i` high and `retire_i` low adds 8 to the counter.
- R6: In modes 10 and 11, each cycle with `retire_i` high and `mispredict_i` low subtracts 1, and `conservative_o` equals counter bit 7.
- R7: On an increment, the counter saturates at 255 instead of wrapping.
- R8: On a decrement, the counter saturates at 0 instead of wrapping.
- R9: When `mispredict_i` and `retire_i` are both high in the same cycle, the counter moves by (step − 1) in that single cycle.
- R10: Writing mode 00 or 01 clears the counter. Writing 10 or 11 keeps the counter's current value. In modes 00 and 01 the counter does not move.
- R11: `conservative_o` is registered. It changes at the clock edge that captures the write or pulse causing the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_we_i | input | 1 | Write strobe for the mode field |
| cfg_mode_i | input | 2 | Mode field value, decoded from bits [5:4] of the control word |
| mispredict_i | input | 1 | One pulse per branch mispredict |
| retire_i | input | 1 | One pulse per retired conditional branch |
| conservative_o | output | 1 | Request for conservative operation |

## Verification
The bench pushes the counter across the 127/128 boundary and checks both sides. A wrong step size would move the crossing to a different mispredict count. Underflow at 0 and overflow at 255 are checked after long runs of pulses. A wrapping counter would show up as an early rise or an early fall of the output. Simultaneous pulses are checked on the edge where only the net change lands on the correct side of 128. The bench also switches between the adaptive modes, and writes the fixed modes, to catch a clear that fires on the wrong writes and a write strobe that is ignored.

// File: rtl/smc_pkg.sv
package smc_pkg;

    typedef enum logic [1:0] {
        SMC_FULL  = 2'b00,
        SMC_FORCE = 2'b01,
        SMC_PER4  = 2'b10,
        SMC_PER8  = 2'b11
    } smc_mode_e;

    function automatic logic smc_is_adaptive(smc_mode_e m);
        return m[1];
    endfunction

endpackage

// File: rtl/smc_mode_reg.sv
module smc_mode_reg
    import smc_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      we_i,
    input  logic [1:0] mode_wr_i,
    output smc_mode_e mode_q_o,
    output smc_mode_e mode_d_o,
    output logic      clr_o
);

    typedef struct packed {
        smc_mode_e mode;
    } mode_st_t;

    mode_st_t st_d, st_q;

    always_comb begin
        st_d  = st_q;
        clr_o = 1'b0;
        if (we_i) begin
            st_d.mode = smc_mode_e'(mode_wr_i);
            clr_o     = !smc_is_adaptive(smc_mode_e'(mode_wr_i));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{mode: SMC_FULL};
        else        st_q <= st_d;
    end

    assign mode_q_o = st_q.mode;
    assign mode_d_o = st_d.mode;

    assert_hold_without_we_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !we_i |=> $stable(mode_q_o));

endmodule

// File: rtl/smc_conf_counter.sv
module smc_conf_counter
    import smc_pkg::*;
#(
    parameter int CNT_W   = 8,
    parameter int STEP_LO = 4,
    parameter int STEP_HI = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  smc_mode_e        mode_i,
    input  logic             clr_i,
    input  logic             inc_i,
    input  logic             dec_i,
    output logic [CNT_W-1:0] cnt_q_o,
    output logic [CNT_W-1:0] cnt_d_o
);

    localparam int SUM_W = CNT_W + 2;
    localparam logic [SUM_W-1:0] CNT_MAX = SUM_W'((1 << CNT_W) - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_st_t;

    cnt_st_t          st_d, st_q;
    logic [SUM_W-1:0] step_w;
    logic [SUM_W-1:0] sum_w;
    logic             active_w;

    always_comb begin
        step_w   = (mode_i == SMC_PER8) ? SUM_W'(STEP_HI) : SUM_W'(STEP_LO);
        active_w = smc_is_adaptive(mode_i) && !clr_i;
        sum_w    = {2'b00, st_q.cnt};
        if (inc_i)                    sum_w = sum_w + step_w;
        if (dec_i && sum_w != '0)     sum_w = sum_w - SUM_W'(1);
        if (sum_w > CNT_MAX)          sum_w = CNT_MAX;
        st_d = st_q;
        if (clr_i)         st_d.cnt = '0;
        else if (active_w) st_d.cnt = sum_w[CNT_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{cnt: '0};
        else        st_q <= st_d;
    end

    assign cnt_q_o = st_q.cnt;
    assign cnt_d_o = st_d.cnt;

    assert_clear_on_fixed_R10: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (cnt_q_o == '0));

    assert_top_saturate_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (smc_is_adaptive(mode_i) && !clr_i && inc_i && cnt_q_o == CNT_MAX[CNT_W-1:0])
        |=> (cnt_q_o == CNT_MAX[CNT_W-1:0]));

    assert_floor_saturate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (smc_is_adaptive(mode_i) && !clr_i && dec_i && !inc_i && cnt_q_o == '0)
        |=> (cnt_q_o == '0));

    assert_step_lo_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == SMC_PER4 && !clr_i && inc_i && !dec_i && cnt_q_o < 8'd200)
        |=> (cnt_q_o == $past(cnt_q_o) + CNT_W'(STEP_LO)));

    assert_step_hi_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == SMC_PER8 && !clr_i && inc_i && !dec_i && cnt_q_o < 8'd200)
        |=> (cnt_q_o == $past(cnt_q_o) + CNT_W'(STEP_HI)));

    assert_fixed_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!smc_is_adaptive(mode_i) && !clr_i) |=> $stable(cnt_q_o));

endmodule

// File: rtl/spec_throttle_ctrl.sv
module spec_throttle_ctrl
    import smc_pkg::*;
#(
    parameter int CNT_W   = 8,
    parameter int STEP_LO = 4,
    parameter int STEP_HI = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_we_i,
    input  logic [1:0] cfg_mode_i,
    input  logic       mispredict_i,
    input  logic       retire_i,
    output logic       conservative_o
);

    localparam int MSB = CNT_W - 1;

    typedef struct packed {
        logic cons;
    } out_st_t;

    smc_mode_e        mode_q, mode_d;
    logic             clr_w;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    out_st_t          st_d, st_q;

    smc_mode_reg u_mode (
        .clk       (clk),
        .rst_n     (rst_n),
        .we_i      (cfg_we_i),
        .mode_wr_i (cfg_mode_i),
        .mode_q_o  (mode_q),
        .mode_d_o  (mode_d),
        .clr_o     (clr_w)
    );

    smc_conf_counter #(
        .CNT_W   (CNT_W),
        .STEP_LO (STEP_LO),
        .STEP_HI (STEP_HI)
    ) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode_i  (mode_q),
        .clr_i   (clr_w),
        .inc_i   (mispredict_i),
        .dec_i   (retire_i),
        .cnt_q_o (cnt_q),
        .cnt_d_o (cnt_d)
    );

    always_comb begin
        st_d = st_q;
        unique case (mode_d)
            SMC_FULL:  st_d.cons = 1'b0;
            SMC_FORCE: st_d.cons = 1'b1;
            default:   st_d.cons = cnt_d[MSB];
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{cons: 1'b0};
        else        st_q <= st_d;
    end

    assign conservative_o = st_q.cons;

    assert_full_spec_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == SMC_FULL) |-> !conservative_o);

    assert_forced_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == SMC_FORCE) |-> conservative_o);

    assert_msb_tracks_R6: assert property (@(posedge clk) disable iff (!rst_n)
        smc_is_adaptive(mode_q) |-> (conservative_o == cnt_q[MSB]));

    assert_clear_output_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we_i && cfg_mode_i == 2'b00) |=> !conservative_o);

endmodule

// File: tb/spec_throttle_ctrl_tb.sv
module spec_throttle_ctrl_tb;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [1:0] cfg_mode = 2'b00;
    logic       mispredict = 1'b0;
    logic       retire = 1'b0;
    logic       conservative;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    spec_throttle_ctrl u_dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .cfg_we_i       (cfg_we),
        .cfg_mode_i     (cfg_mode),
        .mispredict_i   (mispredict),
        .retire_i       (retire),
        .conservative_o (conservative)
    );

    task automatic check(input string req, input logic exp);
        n_checks++;
        if (conservative !== exp) begin
            n_fails++;
            $display("FAIL %s: conservative_o=%b expected=%b at %0t", req, conservative, exp, $time);
        end
    endtask

    // drive for one edge, then return at the following negedge
    task automatic step(input logic mp, input logic rt);
        mispredict = mp;
        retire     = rt;
        @(posedge clk);
        @(negedge clk);
        mispredict = 1'b0;
        retire     = 1'b0;
    endtask

    task automatic pulses(input int n, input logic mp, input logic rt);
        for (int i = 0; i < n; i++) step(mp, rt);
    endtask

    task automatic write_mode(input logic [1:0] m);
        cfg_we   = 1'b1;
        cfg_mode = m;
        @(posedge clk);
        @(negedge clk);
        cfg_we   = 1'b0;
        cfg_mode = 2'b00;
    endtask

    task automatic t_reset_and_strobe();
        check("R1", 1'b0);
        cfg_mode = 2'b01;          // no strobe: must be ignored
        pulses(2, 1'b0, 1'b0);
        check("R1", 1'b0);
        write_mode(2'b01);
        check("R3", 1'b1);
        pulses(5, 1'b1, 1'b0);
        check("R3", 1'b1);
        write_mode(2'b00);
        check("R2", 1'b0);
        pulses(40, 1'b1, 1'b0);    // mode 00: no counting, stays low
        check("R2", 1'b0);
    endtask

    task automatic t_step4();
        write_mode(2'b00);
        write_mode(2'b10);
        pulses(31, 1'b1, 1'b0);    // 124
        check("R4", 1'b0);
        pulses(1, 1'b1, 1'b0);     // 128, visible right after the edge
        check("R11", 1'b1);
        pulses(1, 1'b0, 1'b1);     // 127
        check("R6", 1'b0);
    endtask

    task automatic t_step8();
        write_mode(2'b00);
        write_mode(2'b11);
        pulses(15, 1'b1, 1'b0);    // 120
        check("R5", 1'b0);
        pulses(1, 1'b1, 1'b0);     // 128
        check("R5", 1'b1);
    endtask

    task automatic t_both_pulses();
        write_mode(2'b00);
        write_mode(2'b10);
        pulses(31, 1'b1, 1'b0);    // 124
        pulses(1, 1'b1, 1'b1);     // 127
        check("R9", 1'b0);
        pulses(1, 1'b1, 1'b1);     // 130
        check("R9", 1'b1);
    endtask

    task automatic t_saturate_top();
        write_mode(2'b00);
        write_mode(2'b11);
        pulses(40, 1'b1, 1'b0);    // clamps at 255
        check("R7", 1'b1);
        pulses(127, 1'b0, 1'b1);   // 128
        check("R7", 1'b1);
        pulses(1, 1'b0, 1'b1);     // 127
        check("R7", 1'b0);
    endtask

    task automatic t_saturate_floor();
        write_mode(2'b00);
        write_mode(2'b10);
        pulses(10, 1'b0, 1'b1);    // stays 0
        check("R8", 1'b0);
        pulses(31, 1'b1, 1'b0);    // 124
        check("R8", 1'b0);
        pulses(1, 1'b1, 1'b0);     // 128
        check("R8", 1'b1);
    endtask

    task automatic t_mode_switch_clear();
        write_mode(2'b00);
        write_mode(2'b10);
        pulses(32, 1'b1, 1'b0);    // 128
        write_mode(2'b11);         // counter kept
        check("R10", 1'b1);
        write_mode(2'b10);
        check("R10", 1'b1);
        write_mode(2'b01);         // clears counter
        check("R10", 1'b1);
        write_mode(2'b10);         // counter now 0
        check("R10", 1'b0);
        pulses(31, 1'b1, 1'b0);    // 124: proves the clear
        check("R10", 1'b0);
    endtask

    initial begin
        fork
            begin
                repeat (3) @(negedge clk);
                rst_n = 1'b1;
                @(negedge clk);
                t_reset_and_strobe();
                t_step4();
                t_step8();
                t_both_pulses();
                t_saturate_top();
                t_saturate_floor();
                t_mode_switch_clear();
                done = 1'b1;
            end
            begin
                for (int c = 0; c < WATCHDOG && !done; c++) @(posedge clk);
                if (!done) begin
                    n_checks++;
                    n_fails++;
                    $display("FAIL watchdog: actual=timeout expected=completion");
                end
            end
        join_any
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule